// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the software-facing programming port of a single eight-line interrupt controller. It accepts byte writes on two addresses and turns them into register updates for the controller core: the vector base, the nesting and automatic end-of-interrupt modes, the line mask, the rotating priority base, and clears of in-service bits. A write to address 0 with bit 4 set starts a short setup sequence. Later writes to address 1 carry that sequence forward. Once the sequence is idle, the same address loads the mask.

The request and in-service registers are held here. Requests are set by the trigger logic through `req_set`, and service bits are set by the acknowledge path through `svc_set`. Commands clear them, and so does a poll read. The priority arbitration stays outside this block. Its winner arrives on `win_valid`/`win_line` and is used only for poll reads. A separate edge/level selection register is written through its own strobe, and only the bits a fixed allow-mask permits are kept.

Reads are combinational from the registers. Register updates happen at the clock edge on a strobe.

Top module: `pic_cmd_port`

## Requirements
- R1: After a synchronous reset the following are all zero: request, in-service, mask, edge/level, vector base, priority base, modes and special mask. The sequencer is idle, and an address-0 read returns the request register.
- R2: An address-0 write with bit 4 set clears the mask, priority base, special mask and read select (read select returns to request). It keeps only those request bits whose edge/level bit is 1. It clears nested mode and auto-EOI only when data bit 0 is 0, and it sets `init_busy`.
- R3: After such a write, the first address-1 write loads the vector base from bits 7:3. The second address-1 write changes nothing. If bit 0 was 1, a third address-1 write sets nested mode from bit 4 and auto-EOI from bit 1. The sequencer then returns to idle (`init_busy` = 0).
- R4: With the sequencer idle, an address-1 write loads the mask, and an address-1 read returns it.
- R5: An address-0 write with bit 4 = 0 and bit 3 = 1 is a read-control command, with three independent fields. Bit 2 = 1 arms poll mode. When bit 1 = 1, bit 0 picks the address-0 read source (1 = in-service, 0 = request). When bit 6 = 1, bit 5 becomes the special mask.
- R6: An address-0 write with bits 4:3 = 00 is an operation command coded in bits 7:5. Codes 000 and 100 set rotate-on-auto-EOI from bit 7. Code 010 changes nothing.
- R7: Code 001 clears the in-service bit that comes first in the order priority base, base+1, … (mod 8). When no in-service bit is set, it changes nothing. Code 101 does the same and also sets the priority base to the cleared line + 1 (mod 8).
- R8: Code 011 clears the in-service bit named by bits 2:0. Code 111 does the same and also sets the priority base to that line + 1 (mod 8).
- R9: Code 110 sets the priority base to bits 2:0 + 1 (mod 8).
- R10: While poll mode is armed, reads on either address return the winning line in bits 2:0 with the upper bits zero, or 7 when no line wins. A read strobe then clears the winner's request and in-service bits and disarms poll mode.
- R11: An edge/level write stores the data ANDed with an allow-mask: 0xF8 when `IS_MASTER` = 1 and 0xDE otherwise.
- R12: A 1 on any bit of `req_set` or `svc_set` sets the matching request or in-service bit at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Command byte write strobe |
| wr_addr | input | 1 | Command write address (0 or 1) |
| wr_data | input | 8 | Command write byte |
| rd_stb | input | 1 | Read strobe (consumes a poll result) |
| rd_addr | input | 1 | Read address (0 or 1) |
| rd_data | output | 8 | Read byte |
| lvl_wr | input | 1 | Edge/level register write strobe |
| lvl_data | input | 8 | Edge/level write byte |
| req_set | input | 8 | Request set pulses from trigger logic |
| svc_set | input | 8 | In-service set pulses from acknowledge path |
| win_valid | input | 1 | Arbitration has a winner |
| win_line | input | 3 | Winning line number |
| req_q | output | 8 | Request register |
| svc_q | output | 8 | In-service register |
| mask_q | output | 8 | Mask register |
| lvl_q | output | 8 | Edge/level register (1 = level) |
| vec_base | output | 5 | Vector base, upper five bits |
| prio_base | output | 3 | Line with highest rotating priority |
| nest_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| rot_auto_eoi | output | 1 | Rotate on automatic end-of-interrupt |
| spec_mask | output | 1 | Special mask mode |
| init_busy | output | 1 | Setup sequence in progress |

## Verification
Some properties are checked on every cycle by the assertions:
- a setup start clears the mask, priority base and special mask;
- the sequencer moves from the base step to the ignored step;
- an idle address-1 write lands in the mask;
- a non-specific end-of-interrupt on a non-empty in-service register drops exactly one bit;
- a consumed poll read disarms polling.

Which bit a non-specific clear removes under each rotation base can only be shown by the bench scenarios, as can the retained or cleared modes for each setup variant, the masked edge/level values and the poll return codes. The bench sweeps every base against several in-service patterns, and every line and every edge/level byte.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    // Setup sequencer position
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_CASC = 2'd2,
        SEQ_MODE = 2'd3
    } seq_t;

    // Operation command codes carried in bits 7:5
    typedef enum logic [2:0] {
        OP_ROT_CLR = 3'd0,
        OP_NS_EOI  = 3'd1,
        OP_NOP     = 3'd2,
        OP_SP_EOI  = 3'd3,
        OP_ROT_SET = 3'd4,
        OP_NS_ROT  = 3'd5,
        OP_SET_PRI = 3'd6,
        OP_SP_ROT  = 3'd7
    } op_t;

    typedef struct packed {
        logic is_init;
        logic is_rdctl;
        logic is_op;
        op_t  op;
    } cmd_dec_t;

    // Bits of the edge/level register that may be written
    function automatic logic [7:0] lvl_allow(input bit master);
        return master ? 8'hF8 : 8'hDE;
    endfunction

endpackage

// File: rtl/pic_cmd_dec.sv
module pic_cmd_dec
    import pic_cmd_pkg::*;
(
    input  logic [7:3] hi_bits,
    output cmd_dec_t   dec
);
    always_comb begin
        dec.is_init  = hi_bits[4];
        dec.is_rdctl = !hi_bits[4] && hi_bits[3];
        dec.is_op    = !hi_bits[4] && !hi_bits[3];
        dec.op       = op_t'(hi_bits[7:5]);
    end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic four_req,
    input  logic wr1,
    output logic ld_base,
    output logic ld_mode,
    output logic ld_mask,
    output logic busy
);
    seq_t state;
    logic want4;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            want4 <= 1'b0;
        end else if (start) begin
            state <= SEQ_BASE;
            want4 <= four_req;
        end else if (wr1) begin
            case (state)
                SEQ_BASE: state <= SEQ_CASC;
                SEQ_CASC: state <= want4 ? SEQ_MODE : SEQ_IDLE;
                SEQ_MODE: state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        ld_base = wr1 && !start && (state == SEQ_BASE);
        ld_mode = wr1 && !start && (state == SEQ_MODE);
        ld_mask = wr1 && !start && (state == SEQ_IDLE);
        busy    = (state != SEQ_IDLE);
    end

    // R3: the base step is always followed by the ignored step
    p_seq_order_r3: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_BASE && wr1 && !start) |=> (state == SEQ_CASC));

endmodule

// File: rtl/pic_eoi_pick.sv
module pic_eoi_pick #(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic [LINES-1:0] svc,
    input  logic [LW-1:0]    base,
    output logic             found,
    output logic [LW-1:0]    line
);
    logic [LW-1:0] idx;

    // Walk from lowest to highest priority; the last hit is the best one
    always_comb begin
        found = 1'b0;
        line  = '0;
        idx   = '0;
        for (int k = LINES - 1; k >= 0; k--) begin
            idx = base + LW'(k);
            if (svc[idx]) begin
                found = 1'b1;
                line  = idx;
            end
        end
    end
endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
    import pic_cmd_pkg::*;
#(
    parameter int LINES     = 8,   // command encoding assumes eight lines
    parameter bit IS_MASTER = 1'b1,
    localparam int LW = $clog2(LINES),
    localparam int VW = LINES - LW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic             wr_addr,
    input  logic [LINES-1:0] wr_data,
    input  logic             rd_stb,
    input  logic             rd_addr,
    output logic [LINES-1:0] rd_data,
    input  logic             lvl_wr,
    input  logic [LINES-1:0] lvl_data,
    input  logic [LINES-1:0] req_set,
    input  logic [LINES-1:0] svc_set,
    input  logic             win_valid,
    input  logic [LW-1:0]    win_line,
    output logic [LINES-1:0] req_q,
    output logic [LINES-1:0] svc_q,
    output logic [LINES-1:0] mask_q,
    output logic [LINES-1:0] lvl_q,
    output logic [VW-1:0]    vec_base,
    output logic [LW-1:0]    prio_base,
    output logic             nest_mode,
    output logic             auto_eoi,
    output logic             rot_auto_eoi,
    output logic             spec_mask,
    output logic             init_busy
);
    localparam logic [LINES-1:0] ALLOW = lvl_allow(IS_MASTER);

    cmd_dec_t         dec;
    logic             init_go, rdctl_go, op_go;
    logic             ld_base, ld_mode, ld_mask;
    logic             pick_found;
    logic [LW-1:0]    pick_line;
    logic             poll_q, rd_svc_sel, poll_take;
    logic [LINES-1:0] svc_clr, poll_clr;
    logic [LW-1:0]    prio_n;

    pic_cmd_dec u_dec (
        .hi_bits (wr_data[7:3]),
        .dec     (dec)
    );

    pic_init_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (init_go),
        .four_req (wr_data[0]),
        .wr1      (wr_stb && wr_addr),
        .ld_base  (ld_base),
        .ld_mode  (ld_mode),
        .ld_mask  (ld_mask),
        .busy     (init_busy)
    );

    pic_eoi_pick #(.LINES(LINES)) u_pick (
        .svc   (svc_q),
        .base  (prio_base),
        .found (pick_found),
        .line  (pick_line)
    );

    always_comb begin
        init_go   = wr_stb && !wr_addr && dec.is_init;
        rdctl_go  = wr_stb && !wr_addr && dec.is_rdctl;
        op_go     = wr_stb && !wr_addr && dec.is_op;
        poll_take = rd_stb && poll_q && win_valid;
        poll_clr  = poll_take ? (LINES'(1) << win_line) : '0;

        svc_clr = '0;
        prio_n  = prio_base;
        if (init_go) begin
            prio_n = '0;
        end else if (op_go) begin
            case (dec.op)
                OP_NS_EOI, OP_NS_ROT: if (pick_found) begin
                    svc_clr = LINES'(1) << pick_line;
                    if (dec.op == OP_NS_ROT) prio_n = pick_line + LW'(1);
                end
                OP_SP_EOI: svc_clr = LINES'(1) << wr_data[LW-1:0];
                OP_SP_ROT: begin
                    svc_clr = LINES'(1) << wr_data[LW-1:0];
                    prio_n  = wr_data[LW-1:0] + LW'(1);
                end
                OP_SET_PRI: prio_n = wr_data[LW-1:0] + LW'(1);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q        <= '0;
            svc_q        <= '0;
            mask_q       <= '0;
            lvl_q        <= '0;
            vec_base     <= '0;
            prio_base    <= '0;
            nest_mode    <= 1'b0;
            auto_eoi     <= 1'b0;
            rot_auto_eoi <= 1'b0;
            spec_mask    <= 1'b0;
            rd_svc_sel   <= 1'b0;
            poll_q       <= 1'b0;
        end else begin
            req_q     <= ((init_go ? (req_q & lvl_q) : req_q) & ~poll_clr) | req_set;
            svc_q     <= (svc_q & ~svc_clr & ~poll_clr) | svc_set;
            prio_base <= prio_n;

            if (init_go)      mask_q <= '0;
            else if (ld_mask) mask_q <= wr_data;

            if (ld_base) vec_base <= wr_data[LINES-1:LW];

            if (init_go && !wr_data[0]) begin
                nest_mode <= 1'b0;
                auto_eoi  <= 1'b0;
            end else if (ld_mode) begin
                nest_mode <= wr_data[4];
                auto_eoi  <= wr_data[1];
            end

            if (init_go) begin
                spec_mask  <= 1'b0;
                rd_svc_sel <= 1'b0;
            end else if (rdctl_go) begin
                if (wr_data[6]) spec_mask  <= wr_data[5];
                if (wr_data[1]) rd_svc_sel <= wr_data[0];
            end

            if (rd_stb) poll_q <= 1'b0;
            if (rdctl_go && wr_data[2]) poll_q <= 1'b1;

            if (op_go && (dec.op == OP_ROT_CLR || dec.op == OP_ROT_SET))
                rot_auto_eoi <= wr_data[7];

            if (lvl_wr) lvl_q <= lvl_data & ALLOW;
        end
    end

    always_comb begin
        if (poll_q)
            rd_data = win_valid ? LINES'(win_line) : LINES'(LINES - 1);
        else if (rd_addr)
            rd_data = mask_q;
        else
            rd_data = rd_svc_sel ? svc_q : req_q;
    end

    // R2: setup start clears mask, priority base and special mask
    p_init_clear_r2: assert property (@(posedge clk) disable iff (rst)
        init_go |=> (mask_q == '0 && prio_base == '0 && !spec_mask));

    // R4: idle address-1 write lands in the mask
    p_mask_load_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr && !init_busy) |=> (mask_q == $past(wr_data)));

    // R7: a non-specific clear removes exactly one in-service bit
    p_ns_one_bit_r7: assert property (@(posedge clk) disable iff (rst)
        (op_go && (dec.op == OP_NS_EOI || dec.op == OP_NS_ROT) && svc_q != '0
         && svc_set == '0 && !poll_take)
        |=> ($countones(svc_q) == $countones($past(svc_q)) - 1));

    // R10: a consumed poll read leaves polling disarmed
    p_poll_disarm_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && poll_q && !(rdctl_go && wr_data[2])) |=> !poll_q);

endmodule

// File: tb/sim_pic_cmd_port.sv
module sim_pic_cmd_port;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_stb = 0, wr_addr = 0, rd_stb = 0, rd_addr = 0, lvl_wr = 0, win_valid = 0;
    logic [7:0] wr_data = 0, lvl_data = 0, req_set = 0, svc_set = 0;
    logic [2:0] win_line = 0;
    logic [7:0] rd_data, req_q, svc_q, mask_q, lvl_q;
    logic [4:0] vec_base;
    logic [2:0] prio_base;
    logic       nest_mode, auto_eoi, rot_auto_eoi, spec_mask, init_busy;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pic_cmd_port u0 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data),
        .lvl_wr(lvl_wr), .lvl_data(lvl_data), .req_set(req_set), .svc_set(svc_set),
        .win_valid(win_valid), .win_line(win_line),
        .req_q(req_q), .svc_q(svc_q), .mask_q(mask_q), .lvl_q(lvl_q),
        .vec_base(vec_base), .prio_base(prio_base), .nest_mode(nest_mode),
        .auto_eoi(auto_eoi), .rot_auto_eoi(rot_auto_eoi), .spec_mask(spec_mask),
        .init_busy(init_busy)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 0;
    endtask

    task automatic set_bits(input logic [7:0] r, input logic [7:0] s);
        @(negedge clk);
        req_set = r; svc_set = s;
        @(negedge clk);
        req_set = 0; svc_set = 0;
    endtask

    task automatic load_svc(input logic [7:0] p);
        for (int l = 0; l < 8; l++) wr(0, 8'h60 | 8'(l));
        set_bits(8'h00, p);
    endtask

    function automatic int first_set(input logic [7:0] p, input int b);
        for (int k = 0; k < 8; k++)
            if (p[(b + k) % 8]) return (b + k) % 8;
        return -1;
    endfunction

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd_addr = 0; #0.1;
        chk("R1 req read", rd_data, 8'h00);
        chk("R1 mask", mask_q, 8'h00);
        chk("R1 lvl", lvl_q, 8'h00);
        chk("R1 base/prio", {vec_base, prio_base}, 8'h00);
        chk("R1 modes", {3'b0, nest_mode, auto_eoi, rot_auto_eoi, spec_mask, init_busy}, 8'h00);

        // R11 every edge/level byte
        for (int v = 0; v < 256; v++) begin
            @(negedge clk); lvl_wr = 1; lvl_data = 8'(v);
            @(negedge clk); lvl_wr = 0;
            chk("R11 lvl mask", lvl_q, 8'(v) & 8'hF8);
        end
        @(negedge clk); lvl_wr = 1; lvl_data = 8'h3C; @(negedge clk); lvl_wr = 0;

        // R12 set pulses
        set_bits(8'hFF, 8'h81);
        chk("R12 req set", req_q, 8'hFF);
        chk("R12 svc set", svc_q, 8'h81);

        // R2/R3 setup with a fourth word
        wr(1, 8'h55);
        wr(0, 8'h11);
        chk("R2 keep level reqs", req_q, 8'h38);
        chk("R2 mask cleared", mask_q, 8'h00);
        chk("R2 busy", {7'b0, init_busy}, 8'h01);
        wr(1, 8'h48);
        chk("R3 vector base", {3'b0, vec_base}, 8'h09);
        wr(1, 8'h77);
        chk("R3 ignored word base", {3'b0, vec_base}, 8'h09);
        chk("R3 ignored word mask", mask_q, 8'h00);
        chk("R3 still busy", {7'b0, init_busy}, 8'h01);
        wr(1, 8'h12);
        chk("R3 modes set", {6'b0, nest_mode, auto_eoi}, 8'h03);
        chk("R3 idle", {7'b0, init_busy}, 8'h00);
        // R2 modes retained with bit 0 set
        wr(0, 8'h11);
        chk("R2 modes kept", {6'b0, nest_mode, auto_eoi}, 8'h03);
        wr(1, 8'hF8); wr(1, 8'h00); wr(1, 8'h00);
        chk("R3 modes from word", {6'b0, nest_mode, auto_eoi}, 8'h00);
        wr(1, 8'h00); wr(0, 8'h11); wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h12);
        // R2 modes cleared with bit 0 clear
        wr(0, 8'h10);
        chk("R2 modes cleared", {6'b0, nest_mode, auto_eoi}, 8'h00);
        wr(1, 8'hF8); wr(1, 8'h00);
        chk("R3 three-step idle", {3'b0, vec_base}, 8'h1F);
        chk("R3 idle no fourth", {7'b0, init_busy}, 8'h00);

        // R4 mask sweep
        rd_addr = 1;
        for (int v = 0; v < 16; v++) begin
            wr(1, 8'(v * 17));
            chk("R4 mask read", rd_data, 8'(v * 17));
        end
        wr(1, 8'h00);

        // R5 read control
        load_svc(8'hA5);
        set_bits(8'h42, 8'h00);
        rd_addr = 0;
        wr(0, 8'h0B); #0.1;
        chk("R5 read svc", rd_data, 8'hA5);
        wr(0, 8'h09); #0.1;
        chk("R5 select held", rd_data, 8'hA5);
        wr(0, 8'h0A); #0.1;
        chk("R5 read req", rd_data, req_q);
        wr(0, 8'h68);
        chk("R5 smask on", {7'b0, spec_mask}, 8'h01);
        wr(0, 8'h28);
        chk("R5 smask held", {7'b0, spec_mask}, 8'h01);
        wr(0, 8'h48);
        chk("R5 smask off", {7'b0, spec_mask}, 8'h00);

        // R6 rotate flag and no-op
        wr(0, 8'h80);
        chk("R6 rot set", {7'b0, rot_auto_eoi}, 8'h01);
        wr(0, 8'h00);
        chk("R6 rot clr", {7'b0, rot_auto_eoi}, 8'h00);
        wr(0, 8'h80);
        wr(0, 8'h47);
        chk("R6 nop rot", {7'b0, rot_auto_eoi}, 8'h01);
        chk("R6 nop svc", svc_q, 8'hA5);
        chk("R6 nop prio", {5'b0, prio_base}, 8'h00);

        // R9 set priority sweep
        for (int v = 0; v < 8; v++) begin
            wr(0, 8'hC0 | 8'(v));
            chk("R9 prio", {5'b0, prio_base}, 8'((v + 1) % 8));
        end

        // R7 non-specific clears across bases and patterns
        for (int b = 0; b < 8; b++) begin
            for (int pi = 0; pi < 5; pi++) begin
                for (int rot = 0; rot < 2; rot++) begin
                    logic [7:0] p;
                    int w;
                    case (pi)
                        0: p = 8'h81; 1: p = 8'h24; 2: p = 8'hFF; 3: p = 8'h10;
                        default: p = 8'h00;
                    endcase
                    load_svc(p);
                    wr(0, 8'hC0 | 8'((b + 7) % 8));
                    w = first_set(p, b);
                    wr(0, rot ? 8'hA0 : 8'h20);
                    if (w < 0) begin
                        chk("R7 empty svc", svc_q, 8'h00);
                        chk("R7 empty prio", {5'b0, prio_base}, 8'(b));
                    end else begin
                        chk("R7 clear", svc_q, p & ~(8'h01 << w));
                        chk("R7 prio", {5'b0, prio_base}, rot ? 8'((w + 1) % 8) : 8'(b));
                    end
                end
            end
        end

        // R8 specific clears
        for (int l = 0; l < 8; l++) begin
            set_bits(8'h00, 8'hFF);
            wr(0, 8'h60 | 8'(l));
            chk("R8 specific", svc_q, 8'hFF & ~(8'h01 << l));
            set_bits(8'h00, 8'hFF);
            wr(0, 8'hE0 | 8'(l));
            chk("R8 spec rot svc", svc_q, 8'hFF & ~(8'h01 << l));
            chk("R8 spec rot prio", {5'b0, prio_base}, 8'((l + 1) % 8));
        end

        // R10 poll reads
        wr(1, 8'h3C);
        for (int l = 0; l < 8; l++) begin
            set_bits(8'hFF, 8'hFF);
            wr(0, 8'h0C);
            @(negedge clk);
            win_valid = 1; win_line = 3'(l); rd_addr = 1; rd_stb = 1; #0.1;
            chk("R10 poll value", rd_data, 8'(l));
            @(negedge clk);
            rd_stb = 0; win_valid = 0; #0.1;
            chk("R10 req cleared", req_q, 8'hFF & ~(8'h01 << l));
            chk("R10 svc cleared", svc_q, 8'hFF & ~(8'h01 << l));
            chk("R10 disarmed", rd_data, 8'h3C);
        end
        set_bits(8'hFF, 8'hFF);
        wr(0, 8'h0C);
        @(negedge clk);
        rd_addr = 0; rd_stb = 1; #0.1;
        chk("R10 no winner", rd_data, 8'h07);
        @(negedge clk);
        rd_stb = 0;
        chk("R10 none cleared", req_q & svc_q, 8'hFF);
        rd_addr = 1; #0.1;
        chk("R10 disarmed empty", rd_data, 8'h3C);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule